// File: doc/BRIEF.md
# Full-frame CCD readout timing generator

This block produces the logic-level transfer clocks for a two-phase full-frame CCD: two vertical phases, two complementary horizontal phases, a copy of the first horizontal phase for the last horizontal gate, and the reset-gate pulse. One start request runs a complete exposure cycle. First a flush pass clears the array with extra lines. Then an integration interval holds every vertical phase low. Then a readout pass moves each line into the horizontal register and clocks it out one pixel at a time.

For a downstream analog front end the block also gives a sample strobe for each read pixel, the current line and pixel indices, and single-tick frame start and frame end flags. All timing is counted in master-clock ticks. Pulse widths, setup time and the pixel half-period are parameters. Elaboration refuses a set whose vertical widths or horizontal setup fall below 5 µs, 3 µs and 1 µs at the stated ticks per microsecond, or whose sample and reset timing would not fit inside one pixel. The integration length is taken from an input when the cycle starts.

Top module: `ccd_timing_gen`

## Requirements
- R1: After reset `busy_o`, `v1_o`, `v2_o`, `h2_o`, `rg_o`, `smp_o`, `frame_start_o` and `frame_end_o` are 0, and `h1_o` and `h1l_o` are 1.
- R2: A one-tick `start_i` while idle raises `busy_o` two ticks later. It stays high for exactly (2·LINES+FLUSH_EXTRA)·LT + `int_ticks_i`+1 ticks, where LT = V1_TICKS+V2_TICKS+SETUP_TICKS+2·HALF_TICKS·PIXELS.
- R3: A `start_i` seen while `busy_o` is 1, including the tick on which `frame_end_o` is high, has no effect. Busy length, flag counts and pixel counts are unchanged, and `busy_o` stays low afterwards.
- R4: The flush pass makes LINES+FLUSH_EXTRA vertical transfers (falling edges of `v2_o`) before `frame_start_o`, with no `smp_o`. Readout then makes LINES transfers.
- R5: Between flush and readout there are exactly `int_ticks_i`+1 ticks with `v1_o`=`v2_o`=0, `h1_o`=1 and `h2_o`=0.
- R6: Each line begins with `v1_o` high for V1_TICKS, then `v2_o` high for V2_TICKS. The two are never high together. `h1_o` is 1 throughout and at the `v2_o` falling edge. The first `h1_o` fall comes SETUP_TICKS+HALF_TICKS ticks after the `v2_o` fall.
- R7: Each line holds PIXELS falling edges of `h1_o`, each low interval lasting HALF_TICKS. `h2_o` is always the inverse of `h1_o` and `h1l_o` always equals `h1_o`.
- R8: During readout `smp_o` pulses once per pixel, SMP_DELAY ticks after each `h1_o` fall, for LINES·PIXELS strobes per frame. It is never high together with `rg_o` or `h1_o`.
- R9: `rg_o` rises SMP_DELAY+1 ticks after every `h1_o` fall, in both flush and readout, stays high RG_TICKS ticks, and is low at every `h1_o` fall.
- R10: `frame_start_o` is a one-tick pulse on the tick `v1_o` rises for readout line 0. `frame_end_o` is a one-tick pulse on the last readout pixel tick, and `busy_o` is 0 on the next tick.
- R11: At every `smp_o`, `line_o` gives the readout line index and `pix_o` the pixel index within that line, both counting from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a flush-integrate-readout cycle |
| int_ticks_i | input | INT_W | Integration length minus one, in master ticks |
| busy_o | output | 1 | Cycle in progress |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h1l_o | output | 1 | Last-gate horizontal phase |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Reset-gate pulse |
| smp_o | output | 1 | Pixel sample strobe |
| frame_start_o | output | 1 | First tick of readout |
| frame_end_o | output | 1 | Last tick of readout |
| line_o | output | clog2(LINES+FLUSH_EXTRA+1) | Line index within the current pass |
| pix_o | output | clog2(PIXELS+1) | Pixel index within the current line |

## Verification
The bench targets the seams between phases. The first is the switch from the last flush pixel into integration. A design that began integrating one tick off, or let a vertical phase leak into it, would show a quiet run of the wrong length. The second is the vertical-to-horizontal handover: dropping H1 before the V2 fall, or shortening the setup gap, shows up as a wrong V2-fall-to-first-dump distance. A zero integration length and a start request on the very tick the frame ends are also driven. An off-by-one in the integration counter would stretch busy, and a start gate that read only the internal mode would launch a second frame there. Sample and reset-gate offsets are measured from every H1 fall, so a reset pulse placed ahead of the sample, or running into the next dump, is counted.

// File: rtl/ccdt_pkg.sv
package ccdt_pkg;
  typedef enum logic [1:0] {MD_IDLE, MD_FLUSH, MD_INTEG, MD_READ} mode_e;
  typedef enum logic [1:0] {LP_VA, LP_VB, LP_SETUP, LP_HORIZ} lphase_e;
  typedef struct packed {
    logic va;
    logic vb;
    logic ha;
    logic hb;
    logic rg;
    logic smp;
    logic first;
    logic last;
  } lane_t;
endpackage

// File: rtl/ccdt_line_engine.sv
module ccdt_line_engine
  import ccdt_pkg::*;
#(
  parameter int PIXELS      = 3448,
  parameter int V1_TICKS    = 840,
  parameter int V2_TICKS    = 504,
  parameter int SETUP_TICKS = 168,
  parameter int HALF_TICKS  = 3,
  parameter int SMP_DELAY   = 1,
  parameter int RG_TICKS    = 1,
  parameter int PIX_W       = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output lane_t            lane,
  output logic [PIX_W-1:0] pix
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PIX_TICKS = 2 * HALF_TICKS;
  localparam int CNT_TOP   = imax(imax(V1_TICKS, V2_TICKS), imax(SETUP_TICKS, PIX_TICKS));
  localparam int CNT_W     = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] VA_LAST = CNT_W'(V1_TICKS - 1);
  localparam logic [CNT_W-1:0] VB_LAST = CNT_W'(V2_TICKS - 1);
  localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(SETUP_TICKS - 1);
  localparam logic [CNT_W-1:0] HZ_LAST = CNT_W'(PIX_TICKS - 1);
  localparam logic [CNT_W-1:0] H_FALL  = CNT_W'(HALF_TICKS);
  localparam logic [CNT_W-1:0] SMP_AT  = CNT_W'(HALF_TICKS + SMP_DELAY);
  localparam logic [CNT_W-1:0] RG_LO   = CNT_W'(HALF_TICKS + SMP_DELAY + 1);
  localparam logic [CNT_W-1:0] RG_HI   = CNT_W'(HALF_TICKS + SMP_DELAY + RG_TICKS);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIXELS - 1);

  lphase_e          ph;
  logic [CNT_W-1:0] cnt;
  logic             seg_end;
  logic             in_h;

  always_comb begin
    unique case (ph)
      LP_VA:    seg_end = (cnt == VA_LAST);
      LP_VB:    seg_end = (cnt == VB_LAST);
      LP_SETUP: seg_end = (cnt == SU_LAST);
      default:  seg_end = (cnt == HZ_LAST);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph  <= LP_VA;
      cnt <= '0;
      pix <= '0;
    end else if (seg_end) begin
      cnt <= '0;
      case (ph)
        LP_VA:    ph <= LP_VB;
        LP_VB:    ph <= LP_SETUP;
        LP_SETUP: ph <= LP_HORIZ;
        default: begin
          if (pix == PIX_LAST) begin
            ph  <= LP_VA;
            pix <= '0;
          end else begin
            pix <= pix + 1'b1;
          end
        end
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Phase decode: H1 rests high outside horizontal clocking, so it is high
  // across each vertical transfer and its setup interval.
  always_comb begin
    in_h       = run && (ph == LP_HORIZ);
    lane.va    = run && (ph == LP_VA);
    lane.vb    = run && (ph == LP_VB);
    lane.hb    = in_h && (cnt >= H_FALL);
    lane.ha    = !lane.hb;
    lane.smp   = in_h && (cnt == SMP_AT);
    lane.rg    = in_h && (cnt >= RG_LO) && (cnt <= RG_HI);
    lane.first = run && (ph == LP_VA) && (cnt == '0);
    lane.last  = in_h && seg_end && (pix == PIX_LAST);
  end
endmodule

// File: rtl/ccdt_mode_ctrl.sv
module ccdt_mode_ctrl
  import ccdt_pkg::*;
#(
  parameter int LINES       = 2574,
  parameter int FLUSH_LINES = 2638,
  parameter int INT_W       = 24,
  parameter int LINE_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy_seen,
  input  logic [INT_W-1:0]  int_ticks,
  input  logic              line_first,
  input  logic              line_last,
  output mode_e             mode,
  output logic [LINE_W-1:0] line,
  output logic              run,
  output logic              fs,
  output logic              fe
);
  localparam logic [LINE_W-1:0] FL_LAST = LINE_W'(FLUSH_LINES - 1);
  localparam logic [LINE_W-1:0] RD_LAST = LINE_W'(LINES - 1);

  logic [INT_W-1:0] icnt;
  logic [INT_W-1:0] ilat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MD_IDLE;
      line <= '0;
      icnt <= '0;
      ilat <= '0;
    end else begin
      case (mode)
        MD_IDLE: begin
          // the registered busy flag still covers the tick after the last pixel
          if (start && !busy_seen) begin
            mode <= MD_FLUSH;
            line <= '0;
            ilat <= int_ticks;
          end
        end
        MD_FLUSH: begin
          if (line_last) begin
            if (line == FL_LAST) begin
              mode <= MD_INTEG;
              line <= '0;
              icnt <= '0;
            end else begin
              line <= line + 1'b1;
            end
          end
        end
        MD_INTEG: begin
          if (icnt == ilat) begin
            mode <= MD_READ;
            icnt <= '0;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        default: begin
          if (line_last) begin
            if (line == RD_LAST) begin
              mode <= MD_IDLE;
              line <= '0;
            end else begin
              line <= line + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    run = (mode == MD_FLUSH) || (mode == MD_READ);
    fs  = (mode == MD_READ) && (line == '0) && line_first;
    fe  = (mode == MD_READ) && (line == RD_LAST) && line_last;
  end
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccdt_pkg::*;
#(
  parameter int LINES        = 2574,
  parameter int PIXELS       = 3448,
  parameter int FLUSH_EXTRA  = 64,
  parameter int TICKS_PER_US = 168,
  parameter int V1_TICKS     = 840,
  parameter int V2_TICKS     = 504,
  parameter int SETUP_TICKS  = 168,
  parameter int HALF_TICKS   = 3,
  parameter int SMP_DELAY    = 1,
  parameter int RG_TICKS     = 1,
  parameter int INT_W        = 24
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        start_i,
  input  logic [INT_W-1:0]                            int_ticks_i,
  output logic                                        busy_o,
  output logic                                        v1_o,
  output logic                                        v2_o,
  output logic                                        h1_o,
  output logic                                        h1l_o,
  output logic                                        h2_o,
  output logic                                        rg_o,
  output logic                                        smp_o,
  output logic                                        frame_start_o,
  output logic                                        frame_end_o,
  output logic [$clog2(LINES+FLUSH_EXTRA+1)-1:0]      line_o,
  output logic [$clog2(PIXELS+1)-1:0]                 pix_o
);
  localparam int FLUSH_LINES = LINES + FLUSH_EXTRA;
  localparam int LINE_W      = $clog2(FLUSH_LINES + 1);
  localparam int PIX_W       = $clog2(PIXELS + 1);
  localparam bit CFG_OK =
      (V1_TICKS >= 5 * TICKS_PER_US) && (V2_TICKS >= 3 * TICKS_PER_US) &&
      (SETUP_TICKS >= TICKS_PER_US) && (SMP_DELAY >= 1) && (RG_TICKS >= 1) &&
      (SMP_DELAY + RG_TICKS <= HALF_TICKS - 1) && (LINES >= 1) && (PIXELS >= 1);

  if (!CFG_OK) begin : g_cfg_reject
    $error("ccd_timing_gen: timing parameters violate transfer minimums");
  end

  mode_e             mode;
  lane_t             lane;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              run;
  logic              fs;
  logic              fe;

  ccdt_mode_ctrl #(
    .LINES(LINES), .FLUSH_LINES(FLUSH_LINES), .INT_W(INT_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start_i), .busy_seen(busy_o),
    .int_ticks(int_ticks_i), .line_first(lane.first), .line_last(lane.last),
    .mode(mode), .line(line), .run(run), .fs(fs), .fe(fe)
  );

  ccdt_line_engine #(
    .PIXELS(PIXELS), .V1_TICKS(V1_TICKS), .V2_TICKS(V2_TICKS),
    .SETUP_TICKS(SETUP_TICKS), .HALF_TICKS(HALF_TICKS), .SMP_DELAY(SMP_DELAY),
    .RG_TICKS(RG_TICKS), .PIX_W(PIX_W)
  ) u_line (
    .clk(clk), .rst(rst), .run(run), .lane(lane), .pix(pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o        <= 1'b0;
      v1_o          <= 1'b0;
      v2_o          <= 1'b0;
      h1_o          <= 1'b1;
      h1l_o         <= 1'b1;
      h2_o          <= 1'b0;
      rg_o          <= 1'b0;
      smp_o         <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      line_o        <= '0;
      pix_o         <= '0;
    end else begin
      busy_o        <= (mode != MD_IDLE);
      v1_o          <= lane.va;
      v2_o          <= lane.vb;
      h1_o          <= lane.ha;
      h1l_o         <= lane.ha;
      h2_o          <= lane.hb;
      rg_o          <= lane.rg;
      smp_o         <= lane.smp && (mode == MD_READ);
      frame_start_o <= fs;
      frame_end_o   <= fe;
      line_o        <= line;
      pix_o         <= pix;
    end
  end
endmodule

// File: rtl/ccdt_chk.sv
module ccdt_chk (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic v1_o,
  input logic v2_o,
  input logic h1_o,
  input logic rg_o,
  input logic smp_o,
  input logic frame_start_o,
  input logic frame_end_o
);
  // R6
  vphase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(v1_o && v2_o));
  // R6
  vfall_h1_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(v2_o) |-> h1_o);
  // R9
  rg_at_dump_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(h1_o) |-> !rg_o);
  // R8
  smp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    smp_o |-> (!rg_o && !h1_o && busy_o));
  // R9
  rg_follows_smp_chk: assert property (@(posedge clk) disable iff (rst)
    smp_o |=> rg_o);
  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start_o, frame_end_o}));
  // R10
  end_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> !busy_o);
endmodule

bind ccd_timing_gen ccdt_chk u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .v1_o(v1_o), .v2_o(v2_o),
  .h1_o(h1_o), .rg_o(rg_o), .smp_o(smp_o),
  .frame_start_o(frame_start_o), .frame_end_o(frame_end_o)
);

// File: tb/ccd_timing_gen_test.sv
module ccd_timing_gen_test;
  localparam int LN = 4, PX = 6, FX = 2, TPU = 1;
  localparam int W1 = 5, W2 = 3, WS = 2, HF = 4, SD = 1, RW = 2, IW = 8;
  localparam int FLN = LN + FX;
  localparam int LT  = W1 + W2 + WS + 2 * HF * PX;
  localparam int LW  = $clog2(LN + FX + 1);
  localparam int PW  = $clog2(PX + 1);
  // {integration ticks, start poke cycle (0 = none), expected quiet run}
  localparam int NV = 4;
  localparam int VEC [0:NV-1][0:2] = '{
    '{5, 0, 6},
    '{0, 100, 1},
    '{20, 400, 21},
    '{3, FLN * LT + 4 + LN * LT + 1, 4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [IW-1:0] int_ticks_i = '0;
  logic busy_o, v1_o, v2_o, h1_o, h1l_o, h2_o, rg_o, smp_o;
  logic frame_start_o, frame_end_o;
  logic [LW-1:0] line_o;
  logic [PW-1:0] pix_o;

  always #10 clk = ~clk;

  ccd_timing_gen #(
    .LINES(LN), .PIXELS(PX), .FLUSH_EXTRA(FX), .TICKS_PER_US(TPU),
    .V1_TICKS(W1), .V2_TICKS(W2), .SETUP_TICKS(WS), .HALF_TICKS(HF),
    .SMP_DELAY(SD), .RG_TICKS(RW), .INT_W(IW)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .int_ticks_i(int_ticks_i),
    .busy_o(busy_o), .v1_o(v1_o), .v2_o(v2_o), .h1_o(h1_o), .h1l_o(h1l_o),
    .h2_o(h2_o), .rg_o(rg_o), .smp_o(smp_o), .frame_start_o(frame_start_o),
    .frame_end_o(frame_end_o), .line_o(line_o), .pix_o(pix_o)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor statistics
  bit mon = 1'b0;
  int busy_cnt, fs_cnt, fe_cnt, vf_flush, vf_read, smp_pre, smp_cnt;
  int quiet, quiet_at_fs, v1run, v2run, bad_v1, bad_v2, bad_vh1;
  int since_v2, bad_setup, h1f, lowrun, bad_low, bad_comp, since_h1f;
  int bad_smpd, rgrun, rg_cnt, bad_rg, bad_lp, bad_fe, bad_fs;
  bit setup_pend, p_v1, p_v2, p_h1, p_rg, p_fe;

  task automatic clear_stats();
    busy_cnt = 0; fs_cnt = 0; fe_cnt = 0; vf_flush = 0; vf_read = 0;
    smp_pre = 0; smp_cnt = 0; quiet = 0; quiet_at_fs = -1; v1run = 0; v2run = 0;
    bad_v1 = 0; bad_v2 = 0; bad_vh1 = 0; since_v2 = 0; bad_setup = 0; h1f = 0;
    lowrun = 0; bad_low = 0; bad_comp = 0; since_h1f = 0; bad_smpd = 0;
    rgrun = 0; rg_cnt = 0; bad_rg = 0; bad_lp = 0; bad_fe = 0; bad_fs = 0;
    setup_pend = 0; p_v1 = 0; p_v2 = 0; p_h1 = 1; p_rg = 0; p_fe = 0;
  endtask

  always @(negedge clk) begin
    if (mon) begin
      if (busy_o) busy_cnt++;
      if (p_fe && busy_o) bad_fe++;
      if (frame_end_o) fe_cnt++;
      if (frame_start_o) begin
        fs_cnt++;
        quiet_at_fs = quiet;
        if (!(v1_o && !p_v1)) bad_fs++;
      end
      if (busy_o && !v1_o && !v2_o && h1_o && !h2_o) quiet++;
      else quiet = 0;
      if (v1_o) v1run++;
      else if (p_v1) begin
        if (v1run != W1) bad_v1++;
        v1run = 0;
      end
      if (v2_o) begin
        v2run++;
        if (!h1_o) bad_vh1++;
      end
      if (p_v2 && !v2_o) begin
        if (v2run != W2) bad_v2++;
        v2run = 0;
        if (fs_cnt == 0) vf_flush++; else vf_read++;
        if (!h1_o) bad_vh1++;
        since_v2 = 0;
        setup_pend = 1;
      end else begin
        since_v2++;
      end
      if (p_h1 && !h1_o) begin
        h1f++;
        since_h1f = 0;
        if (setup_pend) begin
          if (since_v2 != WS + HF) bad_setup++;
          setup_pend = 0;
        end
        if (rg_o) bad_rg++;
      end else begin
        since_h1f++;
      end
      if (!h1_o) lowrun++;
      else if (!p_h1) begin
        if (lowrun != HF) bad_low++;
        lowrun = 0;
      end
      if ((h2_o == h1_o) || (h1l_o != h1_o)) bad_comp++;
      if (smp_o) begin
        if (fs_cnt == 0) smp_pre++;
        if (since_h1f != SD) bad_smpd++;
        if ((int'(line_o) != smp_cnt / PX) || (int'(pix_o) != smp_cnt % PX)) bad_lp++;
        smp_cnt++;
      end
      if (rg_o) begin
        if (!p_rg) begin
          rg_cnt++;
          if (since_h1f != SD + 1) bad_rg++;
        end
        rgrun++;
      end else if (p_rg) begin
        if (rgrun != RW) bad_rg++;
        rgrun = 0;
      end
      p_v1 = v1_o; p_v2 = v2_o; p_h1 = h1_o; p_rg = rg_o; p_fe = frame_end_o;
    end
  end

  task automatic check_idle(input string tag);
    chk(!busy_o && !v1_o && !v2_o && !h2_o && !rg_o && !smp_o, {tag, " R1 low outputs"},
        int'({busy_o, v1_o, v2_o, h2_o, rg_o, smp_o}), 0);
    chk(!frame_start_o && !frame_end_o, {tag, " R1 flags"},
        int'({frame_start_o, frame_end_o}), 0);
    chk(h1_o && h1l_o, {tag, " R1 H1 rests high"}, int'({h1_o, h1l_o}), 3);
  endtask

  task automatic run_frame(input int itk, input int poke, input int exp_quiet);
    int cyc;
    bit seen;
    int exp_total;
    exp_total = FLN * LT + itk + 1 + LN * LT;
    clear_stats();
    int_ticks_i = IW'(itk);
    mon = 1'b1;
    @(negedge clk);
    start_i = 1'b1;
    cyc = 0;
    seen = 0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start_i = (cyc == poke);
      if (busy_o) seen = 1;
      else if (seen) break;
    end
    start_i = 1'b0;
    chk(cyc < 5000, "R2 frame completes", cyc, exp_total);
    repeat (3) @(negedge clk);
    mon = 1'b0;
    chk(!busy_o, "R3 no second cycle after late start", int'(busy_o), 0);
    chk(busy_cnt == exp_total, "R2 R3 busy length", busy_cnt, exp_total);
    chk(fs_cnt == 1 && fe_cnt == 1, "R10 R3 one start and one end flag", fs_cnt * 10 + fe_cnt, 11);
    chk(bad_fs == 0 && bad_fe == 0, "R10 flag alignment", bad_fs + bad_fe, 0);
    chk(vf_flush == FLN, "R4 flush transfers", vf_flush, FLN);
    chk(vf_read == LN, "R4 readout transfers", vf_read, LN);
    chk(smp_pre == 0, "R4 no strobe in flush", smp_pre, 0);
    chk(quiet_at_fs == exp_quiet, "R5 integration length", quiet_at_fs, exp_quiet);
    chk(bad_v1 == 0 && bad_v2 == 0, "R6 vertical widths", bad_v1 + bad_v2, 0);
    chk(bad_vh1 == 0, "R6 H1 high during transfer", bad_vh1, 0);
    chk(bad_setup == 0, "R6 setup gap", bad_setup, 0);
    chk(h1f == (FLN + LN) * PX, "R7 H1 falls", h1f, (FLN + LN) * PX);
    chk(bad_low == 0 && bad_comp == 0, "R7 half period and complement", bad_low + bad_comp, 0);
    chk(smp_cnt == LN * PX, "R8 strobe count", smp_cnt, LN * PX);
    chk(bad_smpd == 0, "R8 strobe offset", bad_smpd, 0);
    chk(bad_rg == 0 && rg_cnt == h1f, "R9 reset gate", rg_cnt - bad_rg, h1f);
    chk(bad_lp == 0, "R11 line and pixel index", bad_lp, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("after release");
    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i][0], VEC[i][1], VEC[i][2]);
    end
    // reset in the middle of a frame returns to the rest state
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (200) @(negedge clk);
    chk(busy_o, "R2 busy mid-frame", int'(busy_o), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("mid-frame reset");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy_o, "R1 stays idle after reset", int'(busy_o), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule